// File: doc/BRIEF.md
# Four-Channel Bridge DMA Engine

This block moves data between local memory and a peripheral bus for four independent channels. Software programs each channel through a small memory-mapped register bank. A channel holds a peripheral address, a local address, a byte count, a direction, a control word and two enable bits. When the channel starts, the engine breaks the work into 32-byte bursts and hands them one at a time to a shared burst port. Each burst carries its channel number, both current addresses and the transfer direction.

Every channel also has a status group. It shows the current addresses, the bytes moved so far and a done flag. Software finds the residue by subtracting the status count from the programmed size and keeping the low 28 bits. One interrupt line is shared by all channels. Software polls the done flags to find which channel finished.

The burst port is a valid/ready command interface. Once `bst_valid` is raised for a channel, the channel number and addresses stay unchanged until `bst_ready` is seen high at a clock edge. The one exception is that channel being disabled, which may withdraw the offer. Each handshake counts as one 32-byte burst of eight 32-bit beats. The port may hold `bst_ready` low for as long as it likes. A programmable number of idle cycles follows every accepted burst.

Top module: `burst_dma4`

Register map (byte addresses on `reg_addr`):
- Channel c configuration: `c*32 + 4*w`. The word w is:
  - 0: peripheral address, bits 28:5 kept
  - 1: local address, bits 28:5 kept
  - 2: size, bit 31 is the valid flag, bits 27:5 hold the byte count
  - 3: direction, bit 0
  - 4: control, bits 2:0
  - 5: channel enable, bit 0
  - 6: transfer enable, bit 0
- Wait count: `0x80`, 8 bits.
- Unlock word: `0x84`.
- Channel c status: `0xC0 + c*16 + 4*w`. The word w is:
  - 0: current peripheral address
  - 1: current local address
  - 2: bytes moved
  - 3: done flag in bit 29

## Requirements
- R1: After reset the wait count reads 27, the unlock word reads 0, every channel and status word reads 0, `irq` is 0 and `bst_valid` is 0.
- R2: The address words read back only bits 28:5 (mask 0x1FFFFFE0). The size word reads back bit 31 and bits 27:5. The direction, enable and control words read back bits 0, 0 and 2:0.
- R3: A channel offers bursts only while all of these hold: its channel enable is 1, its transfer enable is 1, size bit 31 is 1, and the unlock word holds 0x4659404F. Burst k of a run carries the programmed addresses plus 32*k, and the status addresses track the next burst.
- R4: A run issues exactly size/32 bursts. It then sets status bit 29, and the status byte count equals the programmed count, so the 28-bit residue is 0. A size of 0 completes without any burst.
- R5: `bst_to_periph` equals the direction bit of the granted channel. A 1 means local memory to the peripheral bus.
- R6: The burst port is granted round-robin among the requesting channels, one burst per grant. The search starts after the channel that last completed a handshake, and channel 0 follows channel 3 after reset.
- R7: After every accepted burst, `bst_valid` stays low for exactly the programmed wait count of cycles.
- R8: `irq` is high while any channel has its done flag set and control bit 1 set. A channel programmed with control 5 completes without raising `irq`.
- R9: Writing status word 3 with bit 29 set clears that channel's done flag and does not restart the channel. Writing it with bit 29 clear has no effect. A transition of the two enables to both 1 also clears the done flag and restarts the channel from the programmed addresses.
- R10: While both enables of a channel are 1, writes to its words 0 through 4 are ignored.
- R11: Writing 0 to either enable withdraws that channel's burst offer from the next cycle. The status words keep the progress reached.
- R12: While `bst_valid` is high and `bst_ready` is low, `bst_chan` and both addresses stay unchanged, unless the offering channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| bst_valid | output | 1 | A burst is offered |
| bst_ready | input | 1 | The burst port accepts the offer |
| bst_chan | output | 2 | Channel of the offered burst |
| bst_local_addr | output | 32 | Local-memory byte address of the burst |
| bst_periph_addr | output | 32 | Peripheral-bus byte address of the burst |
| bst_to_periph | output | 1 | 1 moves local memory to the peripheral bus |
| irq | output | 1 | Shared completion interrupt |

## Verification
The main function is swept over three size mixes: uneven counts on all channels, one burst each, and a mix with two zero-size channels. Each mix runs with wait counts 0 and 3 and with a port that accepts every cycle or only every third cycle. Releasing all channels together through the unlock word makes the round-robin order visible.

An always-ready port shows that the idle gap after a burst is exact. A throttled port shows that a held offer keeps its channel and addresses, so the grant order does not change. The zero-size channels separate completion without traffic from normal completion. Alternating control words 5 and 7 show which done flags drive `irq`.

Directed steps cover the remaining behaviour:
- a single enable, or an invalid size, gives no traffic
- a refused port shows that reprogramming a running channel has no effect
- disabling a stalled channel withdraws its offer while its progress stays in place
- the two ways of clearing done are tried separately

// File: rtl/burst_dma4_pkg.sv
package burst_dma4_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h4659_404F;
  localparam int ADR_W = 24;  // byte address bits 28:5
  localparam int CNT_W = 23;  // byte count bits 27:5
  localparam int WAIT_RST = 27;
  localparam logic [2:0] W_PADR = 3'd0;
  localparam logic [2:0] W_LADR = 3'd1;
  localparam logic [2:0] W_SIZE = 3'd2;
  localparam logic [2:0] W_DIR  = 3'd3;
  localparam logic [2:0] W_CTRL = 3'd4;
  localparam logic [2:0] W_CHEN = 3'd5;
  localparam logic [2:0] W_XEN  = 3'd6;
endpackage

// File: rtl/burst_dma4_chan.sv
module burst_dma4_chan
  import burst_dma4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic             st_we,
  input  logic [31:0]      wdata,
  input  logic [2:0]       rd_cfg,
  input  logic [1:0]       rd_st,
  input  logic             unlocked,
  input  logic             take,
  output logic             req,
  output logic [ADR_W-1:0] cur_p,
  output logic [ADR_W-1:0] cur_l,
  output logic             to_periph,
  output logic             done,
  output logic             evt_en,
  output logic [31:0]      cfg_rdata,
  output logic [31:0]      st_rdata
);
  logic [ADR_W-1:0] p_base, l_base;
  logic [CNT_W-1:0] sz, moved;
  logic             sz_ok, dir_q, chen, xen, fin;
  logic [2:0]       ctl;
  logic             chen_n, xen_n, running, start, go, finish;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[30], wdata[4:3]};
  assign running = chen & xen;

  always_comb begin
    chen_n = chen;
    xen_n  = xen;
    if (cfg_we && cfg_sel == W_CHEN) chen_n = wdata[0];
    if (cfg_we && cfg_sel == W_XEN)  xen_n  = wdata[0];
    start = !running && chen_n && xen_n;
  end

  assign go     = running & sz_ok & unlocked & !fin;
  assign req    = go && (moved != sz);
  assign finish = go && (moved == sz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_base <= '0; l_base <= '0; sz <= '0; sz_ok <= 1'b0;
      dir_q <= 1'b0; ctl <= '0; chen <= 1'b0; xen <= 1'b0;
      cur_p <= '0; cur_l <= '0; moved <= '0; fin <= 1'b0; done <= 1'b0;
    end else begin
      chen <= chen_n;
      xen  <= xen_n;
      if (cfg_we && !running) begin
        case (cfg_sel)
          W_PADR: p_base <= wdata[28:5];
          W_LADR: l_base <= wdata[28:5];
          W_SIZE: begin sz_ok <= wdata[31]; sz <= wdata[27:5]; end
          W_DIR:  dir_q <= wdata[0];
          W_CTRL: ctl <= wdata[2:0];
          default: ;
        endcase
      end
      if (start) begin
        cur_p <= p_base;
        cur_l <= l_base;
        moved <= '0;
        fin   <= 1'b0;
        done  <= 1'b0;
      end else begin
        if (take) begin
          cur_p <= cur_p + ADR_W'(1);
          cur_l <= cur_l + ADR_W'(1);
          moved <= moved + CNT_W'(1);
        end
        if (finish) begin
          fin  <= 1'b1;
          done <= 1'b1;
        end else if (st_we && wdata[29]) begin
          done <= 1'b0;
        end
      end
    end
  end

  assign to_periph = dir_q;
  assign evt_en    = ctl[1];

  always_comb begin
    case (rd_cfg)
      W_PADR:  cfg_rdata = {3'b0, p_base, 5'b0};
      W_LADR:  cfg_rdata = {3'b0, l_base, 5'b0};
      W_SIZE:  cfg_rdata = {sz_ok, 3'b0, sz, 5'b0};
      W_DIR:   cfg_rdata = {31'b0, dir_q};
      W_CTRL:  cfg_rdata = {29'b0, ctl};
      W_CHEN:  cfg_rdata = {31'b0, chen};
      W_XEN:   cfg_rdata = {31'b0, xen};
      default: cfg_rdata = '0;
    endcase
    case (rd_st)
      2'd0:    st_rdata = {3'b0, cur_p, 5'b0};
      2'd1:    st_rdata = {3'b0, cur_l, 5'b0};
      2'd2:    st_rdata = {4'b0, moved, 5'b0};
      default: st_rdata = {2'b0, done, 29'b0};
    endcase
  end

  AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req);  // R6
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req);  // R4
  AST_MOVED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (moved <= sz));  // R4
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(p_base) && $stable(l_base) && $stable(sz)));  // R10
endmodule

// File: rtl/burst_dma4_arb.sv
module burst_dma4_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          allow_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] sel_o,
  output logic [N-1:0]  take_o
);
  logic [IW-1:0] last_q, lock_ch, idx, pick;
  logic          lock_q, found, fire;

  always_comb begin
    pick  = last_q;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      idx = last_q + IW'(k);
      if (!found && req_i[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
    if (lock_q && req_i[lock_ch]) begin
      pick  = lock_ch;
      found = 1'b1;
    end
  end

  assign valid_o = found & allow_i;
  assign sel_o   = pick;
  assign fire    = valid_o & ready_i;

  always_comb begin
    for (int i = 0; i < N; i++) take_o[i] = fire && (pick == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q  <= IW'(N - 1);
      lock_q  <= 1'b0;
      lock_ch <= '0;
    end else begin
      if (fire) last_q <= pick;
      lock_q  <= valid_o & !ready_i;
      lock_ch <= pick;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o));  // R6
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (!req_i[$past(sel_o)] || (valid_o && sel_o == $past(sel_o))));  // R12
endmodule

// File: rtl/burst_dma4_pace.sv
module burst_dma4_pace #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [WW-1:0] gap,
  output logic          ok
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (fire)         cnt <= gap;
    else if (cnt != '0)    cnt <= cnt - WW'(1);
  end

  assign ok = (cnt == '0);
endmodule

// File: rtl/burst_dma4.sv
module burst_dma4
  import burst_dma4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int WAIT_W = 8,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            bst_valid,
  input  logic            bst_ready,
  output logic [CH_W-1:0] bst_chan,
  output logic [31:0]     bst_local_addr,
  output logic [31:0]     bst_periph_addr,
  output logic            bst_to_periph,
  output logic            irq
);
  localparam logic [7:0] A_WAIT   = 8'h80;
  localparam logic [7:0] A_UNLOCK = 8'h84;

  logic [WAIT_W-1:0] wait_q;
  logic [31:0]       key_q;
  logic              unlocked, pace_ok, fire;
  logic              in_cfg, in_st;
  logic [NCH-1:0]    req, take, done, evt_en, dir;
  logic [ADR_W-1:0]  cur_p [NCH];
  logic [ADR_W-1:0]  cur_l [NCH];
  logic [31:0]       cfg_rd [NCH];
  logic [31:0]       st_rd [NCH];

  assign in_cfg   = !reg_addr[7];
  assign in_st    = (reg_addr[7:6] == 2'b11);
  assign unlocked = (key_q == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= WAIT_W'(WAIT_RST);
      key_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_WAIT)   wait_q <= reg_wdata[WAIT_W-1:0];
      if (reg_addr == A_UNLOCK) key_q  <= reg_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    burst_dma4_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (reg_we && in_cfg && reg_addr[6:5] == 2'(c)),
      .cfg_sel   (reg_addr[4:2]),
      .st_we     (reg_we && in_st && reg_addr[5:4] == 2'(c) && reg_addr[3:2] == 2'd3),
      .wdata     (reg_wdata),
      .rd_cfg    (reg_addr[4:2]),
      .rd_st     (reg_addr[3:2]),
      .unlocked  (unlocked),
      .take      (take[c]),
      .req       (req[c]),
      .cur_p     (cur_p[c]),
      .cur_l     (cur_l[c]),
      .to_periph (dir[c]),
      .done      (done[c]),
      .evt_en    (evt_en[c]),
      .cfg_rdata (cfg_rd[c]),
      .st_rdata  (st_rd[c])
    );
  end

  burst_dma4_arb #(.N(NCH), .IW(CH_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .allow_i (pace_ok),
    .ready_i (bst_ready),
    .valid_o (bst_valid),
    .sel_o   (bst_chan),
    .take_o  (take)
  );

  assign fire = bst_valid & bst_ready;

  burst_dma4_pace #(.WW(WAIT_W)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .gap   (wait_q),
    .ok    (pace_ok)
  );

  assign bst_periph_addr = {3'b0, cur_p[bst_chan], 5'b0};
  assign bst_local_addr  = {3'b0, cur_l[bst_chan], 5'b0};
  assign bst_to_periph   = dir[bst_chan];
  assign irq             = |(done & evt_en);

  always_comb begin
    reg_rdata = '0;
    if (in_cfg) begin
      if (int'(reg_addr[6:5]) < NCH) reg_rdata = cfg_rd[reg_addr[6:5]];
    end else if (in_st) begin
      if (int'(reg_addr[5:4]) < NCH) reg_rdata = st_rd[reg_addr[5:4]];
    end else if (reg_addr == A_WAIT) begin
      reg_rdata = 32'(wait_q);
    end else if (reg_addr == A_UNLOCK) begin
      reg_rdata = key_q;
    end
  end

  AST_WAIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wait_q != '0) |=> !bst_valid);  // R7
  AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (key_q == UNLOCK_KEY));  // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done != '0));  // R8
endmodule

// File: tb/burst_dma4_tb_top.sv
module burst_dma4_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bst_valid, bst_to_periph, irq;
  logic        bst_ready = 1'b0;
  logic [1:0]  bst_chan;
  logic [31:0] bst_local_addr, bst_periph_addr;

  always #5 clk = ~clk;

  burst_dma4 dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bst_valid(bst_valid),
    .bst_ready(bst_ready), .bst_chan(bst_chan), .bst_local_addr(bst_local_addr),
    .bst_periph_addr(bst_periph_addr), .bst_to_periph(bst_to_periph), .irq(irq)
  );

  localparam logic [31:0] KEY = 32'h4659_404F;
  int checks = 0, errors = 0, cyc = 0, rmode = 0, nfire = 0, rr_last = 3;
  int          f_ch [512];
  int          f_cy [512];
  logic [31:0] f_p  [512];
  logic [31:0] f_l  [512];
  logic        f_d  [512];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    bst_ready = (rmode == 0) || (rmode == 1 && cyc % 3 == 0);
    #1;
    if (rst_n && bst_valid && bst_ready && nfire < 512) begin
      f_ch[nfire] = int'(bst_chan);
      f_p[nfire]  = bst_periph_addr;
      f_l[nfire]  = bst_local_addr;
      f_d[nfire]  = bst_to_periph;
      f_cy[nfire] = cyc;
      nfire++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycle %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ca(input int ch, input int w);
    return 8'(ch * 32 + w * 4);
  endfunction
  function automatic logic [7:0] sa(input int ch, input int w);
    return 8'(192 + ch * 16 + w * 4);
  endfunction
  function automatic int nb(input int cfg, input int ch);
    case (cfg)
      0: return (ch == 0) ? 3 : (ch == 1) ? 1 : (ch == 2) ? 4 : 2;
      1: return 1;
      default: return (ch == 1) ? 2 : (ch == 3) ? 5 : 0;
    endcase
  endfunction
  function automatic logic [31:0] pb(input int cfg, input int ch);
    return 32'h0400_0000 + 32'(ch) * 32'h1_0000 + 32'(cfg) * 32'h400;
  endfunction
  function automatic logic [31:0] lb(input int cfg, input int ch);
    return 32'h0100_0000 + 32'(ch) * 32'h8000 + 32'(cfg) * 32'h200;
  endfunction

  task automatic run_cfg(input int cfg, input int w, input int rm);
    int rem [4];
    int kk [4];
    int ex [64];
    int tot, base, t, pick;
    bit found, exp_irq;
    logic [31:0] d, s;
    wr(8'h84, 32'h0);
    wr(8'h80, 32'(w));
    for (int ch = 0; ch < 4; ch++) begin
      wr(ca(ch, 5), 0); wr(ca(ch, 6), 0);
      wr(ca(ch, 0), pb(cfg, ch)); wr(ca(ch, 1), lb(cfg, ch));
      wr(ca(ch, 2), 32'h8000_0000 | 32'(nb(cfg, ch) * 32));
      wr(ca(ch, 3), 32'((ch + cfg) % 2));
      wr(ca(ch, 4), ((ch + cfg) % 2 == 1) ? 32'd7 : 32'd5);
      wr(ca(ch, 5), 1); wr(ca(ch, 6), 1);
      rem[ch] = nb(cfg, ch); kk[ch] = 0;
    end
    tot = 0;
    forever begin
      found = 0; pick = 0;
      for (int k = 1; k <= 4; k++)
        if (!found && rem[(rr_last + k) % 4] > 0) begin found = 1; pick = (rr_last + k) % 4; end
      if (!found) break;
      ex[tot] = pick; tot++; rem[pick]--; rr_last = pick;
    end
    base = nfire;
    rmode = rm;
    wr(8'h84, KEY);
    t = 0;
    while (nfire < base + tot && t < 3000) begin @(negedge clk); t++; end
    idle(4);
    rmode = 0;
    chk("R4 burst count", 32'(nfire - base), 32'(tot));
    for (int j = 0; j < tot && base + j < 512; j++) begin
      chk("R6 grant order", 32'(f_ch[base + j]), 32'(ex[j]));
      chk("R3 periph addr", f_p[base + j], pb(cfg, ex[j]) + 32'(32 * kk[ex[j]]));
      chk("R3 local addr", f_l[base + j], lb(cfg, ex[j]) + 32'(32 * kk[ex[j]]));
      chk("R5 direction", 32'(f_d[base + j]), 32'((ex[j] + cfg) % 2));
      kk[ex[j]]++;
      if (j > 0) begin
        if (rm == 0) chk("R7 gap exact", 32'(f_cy[base + j] - f_cy[base + j - 1]), 32'(w + 1));
        else chk("R7 gap minimum", 32'(f_cy[base + j] - f_cy[base + j - 1] >= w + 1), 32'd1);
      end
    end
    exp_irq = 0;
    for (int ch = 0; ch < 4; ch++) begin
      rd(sa(ch, 3), d); chk("R4 done bit", d, 32'h2000_0000);
      rd(sa(ch, 2), s); chk("R4 bytes moved", s, 32'(nb(cfg, ch) * 32));
      rd(ca(ch, 2), d); chk("R4 residue", (d - s) & 32'h0FFF_FFFF, 32'h0);
      rd(sa(ch, 0), d); chk("R3 status periph addr", d, pb(cfg, ch) + 32'(nb(cfg, ch) * 32));
      if ((ch + cfg) % 2 == 1) exp_irq = 1;
    end
    chk("R8 irq after run", 32'(irq), 32'(exp_irq));
  endtask

  initial begin
    logic [31:0] d;
    int n0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h80, d); chk("R1 wait reset", d, 32'd27);
    rd(8'h84, d); chk("R1 unlock reset", d, 32'h0);
    rd(ca(2, 0), d); chk("R1 cfg reset", d, 32'h0);
    rd(sa(3, 3), d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);
    chk("R1 valid reset", 32'(bst_valid), 32'h0);
    // R2 field masks
    wr(ca(1, 0), 32'hFFFF_FFFF); rd(ca(1, 0), d); chk("R2 periph mask", d, 32'h1FFF_FFE0);
    wr(ca(1, 1), 32'hFFFF_FFFF); rd(ca(1, 1), d); chk("R2 local mask", d, 32'h1FFF_FFE0);
    wr(ca(1, 2), 32'hFFFF_FFFF); rd(ca(1, 2), d); chk("R2 size mask", d, 32'h8FFF_FFE0);
    wr(ca(1, 3), 32'hFFFF_FFFF); rd(ca(1, 3), d); chk("R2 dir mask", d, 32'h1);
    wr(ca(1, 4), 32'hFFFF_FFFF); rd(ca(1, 4), d); chk("R2 ctrl mask", d, 32'h7);
    wr(ca(1, 5), 32'hFFFF_FFFF); rd(ca(1, 5), d); chk("R2 enable mask", d, 32'h1);
    wr(ca(1, 5), 0);
    // R3 gating: one enable only, then size without valid flag
    wr(8'h84, KEY);
    wr(ca(0, 0), 32'h100); wr(ca(0, 1), 32'h200); wr(ca(0, 2), 32'h8000_0040);
    wr(ca(0, 5), 1);
    n0 = nfire; idle(10);
    chk("R3 single enable idle", 32'(nfire - n0), 32'h0);
    wr(ca(0, 5), 0); wr(ca(0, 2), 32'h40); wr(ca(0, 5), 1); wr(ca(0, 6), 1);
    idle(10);
    chk("R3 invalid size idle", 32'(nfire - n0), 32'h0);
    rd(sa(0, 3), d); chk("R3 invalid size not done", d, 32'h0);
    wr(ca(0, 5), 0); wr(ca(0, 6), 0);
    // sweep
    for (int cfg = 0; cfg < 3; cfg++)
      for (int wi = 0; wi < 2; wi++)
        for (int rm = 0; rm < 2; rm++)
          run_cfg(cfg, wi * 3, rm);
    // R9 clearing (last sweep: ch1 and ch3 use control 7)
    wr(sa(1, 3), 32'h2000_0000); rd(sa(1, 3), d); chk("R9 clear by write", d, 32'h0);
    chk("R9 irq kept by other channel", 32'(irq), 32'h1);
    wr(sa(3, 3), 32'h0); rd(sa(3, 3), d); chk("R9 zero write ignored", d, 32'h2000_0000);
    wr(sa(3, 3), 32'h2000_0000);
    n0 = nfire; idle(5);
    chk("R9 irq cleared", 32'(irq), 32'h0);
    chk("R9 no restart after clear", 32'(nfire - n0), 32'h0);
    wr(8'h84, 32'h0);
    wr(ca(0, 6), 0); wr(ca(0, 6), 1);
    rd(sa(0, 3), d); chk("R9 re-enable clears done", d, 32'h0);
    // R10, R11, R12 with a refusing port
    rmode = 2;
    wr(8'h80, 32'h0);
    wr(ca(0, 5), 0); wr(ca(0, 6), 0);
    wr(ca(0, 0), 32'h2000); wr(ca(0, 1), 32'h3000); wr(ca(0, 2), 32'h8000_0060);
    wr(ca(0, 3), 1); wr(ca(0, 4), 7);
    wr(ca(0, 5), 1); wr(ca(0, 6), 1);
    wr(8'h84, KEY);
    idle(3); #2;
    chk("R12 offer up", 32'(bst_valid), 32'h1);
    chk("R12 offer chan", 32'(bst_chan), 32'h0);
    chk("R12 offer addr", bst_periph_addr, 32'h2000);
    idle(4); #2;
    chk("R12 offer still held", 32'(bst_valid), 32'h1);
    chk("R12 addr still held", bst_periph_addr, 32'h2000);
    wr(ca(0, 0), 32'h5000); rd(ca(0, 0), d); chk("R10 running write ignored", d, 32'h2000);
    n0 = nfire;
    rmode = 0;
    @(negedge clk); #2;
    rmode = 2;
    idle(2); #2;
    chk("R3 one burst accepted", 32'(nfire - n0), 32'h1);
    chk("R3 next burst addr", bst_periph_addr, 32'h2020);
    wr(ca(0, 6), 0); #2;
    chk("R11 offer withdrawn", 32'(bst_valid), 32'h0);
    rd(sa(0, 2), d); chk("R11 progress kept", d, 32'h20);
    rd(sa(0, 0), d); chk("R11 status addr kept", d, 32'h2020);
    wr(ca(0, 0), 32'h5000); rd(ca(0, 0), d); chk("R10 idle write accepted", d, 32'h5000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule